// File: doc/BRIEF.md
# Dual-Channel Read-Clear Quadrature Counter

This block counts the motion of two incremental encoders. Each channel takes an A/B pair of phase signals that may be slow, noisy and asynchronous to the block's clock. It synchronizes each signal, filters out glitches, decodes every legal phase change into one step up or one step down, and adds that step to a signed two's-complement delta counter. Everything runs on a single externally supplied clock.

The host reads through a small parallel port: it sets a channel select and raises a read strobe. On the rising edge of the strobe the selected channel's count and overflow flag are copied to the output register and the channel's counter is cleared in the same clock, so each read returns only the change since the previous read of that channel. Software keeps an absolute position of any width by adding these deltas. A step that arrives in the very clock of a read becomes the new starting value, so no step is ever lost. A read is always accepted in one clock; the port applies no back-pressure and needs no handshake.

Top module: `qdp_pair`

## Requirements
- R1: After reset, `rd_data` is 0 and `rd_ovf` is 0, and both counters hold 0.
- R2: With the phase pair written as {A,B}, the forward order 00, 10, 11, 01, 00 adds +1 to the channel count for every filtered change.
- R3: The reverse order 00, 01, 11, 10, 00 adds -1 per change, so the count goes negative in two's complement.
- R4: A change in which A and B both flip at once is dropped: the count is unchanged.
- R5: A level on A or B that lasts fewer than `FILT_LEN` clocks is ignored; a level must be seen for `FILT_LEN` consecutive clocks before it is decoded.
- R6: A read returns the selected channel's count accumulated since its previous read and leaves that channel's counter at zero.
- R7: A strobe held high for many clocks acts as one read; steps counted while it is held are returned by the next read.
- R8: A step decoded in the same clock as a read of that channel is not lost: the read returns the old count and the counter restarts at +1 or -1.
- R9: The two channels are independent: a read of one channel, and steps on it, leave the other channel's count unchanged.
- R10: The count wraps on overflow (past the largest positive value to the most negative one) and sets a sticky per-channel overflow flag, returned in `rd_ovf` with the data and cleared by the read.
- R11: `rd_data` and `rd_ovf` change only in the clock after a rising edge of `rd_req` and hold their value until the next such edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the whole block |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 2 | Phase A of each channel, bit n for channel n, asynchronous |
| enc_b | input | 2 | Phase B of each channel, bit n for channel n, asynchronous |
| rd_sel | input | 1 | Channel to read: 0 or 1, sampled with the strobe edge |
| rd_req | input | 1 | Read strobe; its rising edge performs one read-and-clear |
| rd_data | output | CNT_W | Signed delta count of the last read channel |
| rd_ovf | output | 1 | Overflow flag of the last read channel |

## Verification
The checker watches on every clock that the output register moves only after a strobe edge, that a held strobe does not re-read, that a read with no concurrent step leaves the counter at zero, that a concurrent forward step restarts it at one, that a read of channel 1 leaves channel 0 untouched, and that a forward step without a read adds exactly one. Whether the filter rejects short pulses, whether the decoder follows the right phase order and drops double flips, and whether a full wrap raises and clears the overflow flag only show up in the bench's scenarios, which drive encoder waveforms and compare the values read back against totals kept in the bench.

// File: rtl/qdp_pkg.sv
package qdp_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_t;
endpackage

// File: rtl/qdp_filter.sv
// Two-flop synchronizer followed by a run-length filter: the output follows
// the input only after FILT_LEN equal consecutive samples.
module qdp_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [1:0]          sync_q;
  logic [FILT_LEN-1:0] hist_q;
  logic                all_hi;
  logic                all_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= '0;
      dout   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], din};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
      if (all_hi) dout <= 1'b1;
      else if (all_lo) dout <= 1'b0;
    end
  end

  assign all_hi = &hist_q;
  assign all_lo = ~|hist_q;
endmodule

// File: rtl/qdp_decoder.sv
// Turns filtered A/B levels into single steps. Forward order {A,B}:
// 00 -> 10 -> 11 -> 01 -> 00. Double flips decode to no step.
module qdp_decoder
  import qdp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  a,
  input  logic  b,
  output step_t step
);
  logic [1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 2'b00;
    else        prev_q <= {a, b};
  end

  always_comb begin
    case ({prev_q, a, b})
      4'b0010, 4'b1011, 4'b1101, 4'b0100: step = STEP_UP;
      4'b1000, 4'b1110, 4'b0111, 4'b0001: step = STEP_DN;
      default:                            step = STEP_NONE;
    endcase
  end
endmodule

// File: rtl/qdp_delta_counter.sv
// Signed wrapping delta counter with sticky overflow. A clear restarts the
// count at the concurrent step (0, +1 or -1) so no step is lost.
module qdp_delta_counter
  import qdp_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_t            step,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] MAX_POS = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] MIN_NEG = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

  logic wrap;

  assign wrap = ((step == STEP_UP) && (cnt == MAX_POS)) ||
                ((step == STEP_DN) && (cnt == MIN_NEG));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (clr) begin
      ovf <= 1'b0;
      case (step)
        STEP_UP: cnt <= ONE;
        STEP_DN: cnt <= '1;
        default: cnt <= '0;
      endcase
    end else begin
      if (wrap) ovf <= 1'b1;
      case (step)
        STEP_UP: cnt <= cnt + ONE;
        STEP_DN: cnt <= cnt - ONE;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/qdp_pair.sv
module qdp_pair
  import qdp_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int FILT_LEN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       enc_a,
  input  logic [1:0]       enc_b,
  input  logic             rd_sel,
  input  logic             rd_req,
  output logic [CNT_W-1:0] rd_data,
  output logic             rd_ovf
);
  localparam int NCH = 2;

  logic             rd_q;
  logic             rd_rise;
  logic [NCH-1:0]   clr_w;
  step_t            step_w [NCH];
  logic [CNT_W-1:0] cnt_w  [NCH];
  logic [NCH-1:0]   ovf_w;

  always_ff @(posedge clk) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= rd_req;
  end

  assign rd_rise = rd_req & ~rd_q;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic fa, fb;

    qdp_filter #(.FILT_LEN(FILT_LEN)) u_filt_a (
      .clk(clk), .rst_n(rst_n), .din(enc_a[ch]), .dout(fa));
    qdp_filter #(.FILT_LEN(FILT_LEN)) u_filt_b (
      .clk(clk), .rst_n(rst_n), .din(enc_b[ch]), .dout(fb));

    qdp_decoder u_dec (
      .clk(clk), .rst_n(rst_n), .a(fa), .b(fb), .step(step_w[ch]));

    assign clr_w[ch] = rd_rise && (rd_sel == ch[0]);

    qdp_delta_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(step_w[ch]), .clr(clr_w[ch]),
      .cnt(cnt_w[ch]), .ovf(ovf_w[ch]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_ovf  <= 1'b0;
    end else if (rd_rise) begin
      rd_data <= rd_sel ? cnt_w[1] : cnt_w[0];
      rd_ovf  <= rd_sel ? ovf_w[1] : ovf_w[0];
    end
  end
endmodule

// File: rtl/qdp_pair_chk.sv
module qdp_pair_chk
  import qdp_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_req,
  input logic             rd_q,
  input logic             rd_sel,
  input logic [CNT_W-1:0] rd_data,
  input logic             rd_ovf,
  input step_t            step0,
  input logic [CNT_W-1:0] cnt0
);
  logic edge_seen;
  assign edge_seen = rd_req && !rd_q;

  // R11: output register moves only after a strobe edge
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_seen |=> ($stable(rd_data) && $stable(rd_ovf)));

  // R7: a held strobe never re-reads
  a_r7_held_once: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_q) |=> $stable(rd_data));

  // R6: read with no concurrent step leaves zero
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && !rd_sel && step0 == STEP_NONE) |=> (cnt0 == '0));

  // R8: concurrent forward step restarts at one
  a_r8_keep_step: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && !rd_sel && step0 == STEP_UP) |=> (cnt0 == CNT_W'(1)));

  // R9: reading channel 1 leaves channel 0 alone
  a_r9_other_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && rd_sel && step0 == STEP_NONE) |=> $stable(cnt0));

  // R2: a forward step without a read adds one
  a_r2_up_one: assert property (@(posedge clk) disable iff (!rst_n)
    (step0 == STEP_UP && !(edge_seen && !rd_sel)) |=>
      (cnt0 == $past(cnt0) + CNT_W'(1)));
endmodule

bind qdp_pair qdp_pair_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_q(rd_q), .rd_sel(rd_sel),
  .rd_data(rd_data), .rd_ovf(rd_ovf), .step0(step_w[0]), .cnt0(cnt_w[0]));

// File: tb/qdp_pair_tb.sv
module qdp_pair_tb;
  localparam int CNT_W    = 12;
  localparam int FILT_LEN = 3;
  localparam int SETTLE   = FILT_LEN + 5;
  localparam int NV       = 6;
  // vector table: channel, direction (1 = forward), steps, expected read
  localparam int V_CH [NV] = '{0, 0, 1, 1, 0, 1};
  localparam int V_UP [NV] = '{1, 0, 1, 0, 1, 1};
  localparam int V_N  [NV] = '{5, 3, 8, 12, 1, 4};
  localparam int V_EX [NV] = '{5, -3, 8, -12, 1, 4};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       enc_a = '0;
  logic [1:0]       enc_b = '0;
  logic             rd_sel = 1'b0;
  logic             rd_req = 1'b0;
  logic [CNT_W-1:0] rd_data;
  logic             rd_ovf;

  int tests = 0;
  int fails = 0;
  int ph [2] = '{0, 0};
  bit done = 1'b0;

  always #10 clk = ~clk;

  qdp_pair #(.CNT_W(CNT_W), .FILT_LEN(FILT_LEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .rd_sel(rd_sel), .rd_req(rd_req), .rd_data(rd_data), .rd_ovf(rd_ovf));

  task automatic check(string req, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int sx(logic [CNT_W-1:0] v);
    return int'(signed'(v));
  endfunction

  // {A,B} for phase index: 0:00 1:10 2:11 3:01
  task automatic drive(int ch);
    logic [1:0] ab;
    case (ph[ch] & 3)
      0: ab = 2'b00;
      1: ab = 2'b10;
      2: ab = 2'b11;
      default: ab = 2'b01;
    endcase
    enc_a[ch] = ab[1];
    enc_b[ch] = ab[0];
  endtask

  task automatic steps(int ch, int up, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ph[ch] = up ? ph[ch] + 1 : ph[ch] + 3;
      drive(ch);
      repeat (SETTLE) @(negedge clk);
    end
  endtask

  task automatic do_read(int ch);
    @(negedge clk);
    rd_sel = ch[0];
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 data", sx(rd_data), 0);
    check("R1 ovf", int'(rd_ovf), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R6 R9: vector table
    for (int v = 0; v < NV; v++) begin
      steps(V_CH[v], V_UP[v], V_N[v]);
      do_read(V_CH[v]);
      check(V_UP[v] != 0 ? "R2 forward" : "R3 reverse", sx(rd_data), V_EX[v]);
      do_read(V_CH[v]);
      check("R6 cleared", sx(rd_data), 0);
    end

    // R4: double flip dropped
    @(negedge clk);
    ph[0] = ph[0] + 2;
    drive(0);
    repeat (SETTLE) @(negedge clk);
    do_read(0);
    check("R4 double flip", sx(rd_data), 0);

    // R5: short glitch ignored
    @(negedge clk);
    enc_a[1] = ~enc_a[1];
    repeat (FILT_LEN - 1) @(negedge clk);
    enc_a[1] = ~enc_a[1];
    repeat (SETTLE) @(negedge clk);
    do_read(1);
    check("R5 glitch", sx(rd_data), 0);

    // R7 R11: held strobe reads once, data holds while held
    steps(0, 1, 2);
    @(negedge clk);
    rd_sel = 1'b0;
    rd_req = 1'b1;
    @(negedge clk);
    check("R7 first read", sx(rd_data), 2);
    steps(0, 1, 3);
    check("R11 held data", sx(rd_data), 2);
    rd_req = 1'b0;
    do_read(0);
    check("R7 steps during hold", sx(rd_data), 3);

    // R8: step and read in the same clock
    steps(0, 1, 3);
    @(negedge clk);
    ph[0] = ph[0] + 1;
    drive(0);
    repeat (FILT_LEN + 3) @(posedge clk);
    @(negedge clk);
    rd_sel = 1'b0;
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    check("R8 old count", sx(rd_data), 3);
    repeat (SETTLE) @(negedge clk);
    do_read(0);
    check("R8 kept step", sx(rd_data), 1);

    // R9 R10: wrap on channel 1 while channel 0 holds a value
    steps(0, 0, 2);
    steps(1, 1, 1 << (CNT_W - 1));
    do_read(1);
    check("R10 wrapped", sx(rd_data), -(1 << (CNT_W - 1)));
    check("R10 ovf set", int'(rd_ovf), 1);
    do_read(1);
    check("R10 ovf cleared", int'(rd_ovf), 0);
    check("R10 count cleared", sx(rd_data), 0);
    do_read(0);
    check("R9 other channel", sx(rd_data), -2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule